// File: doc/BRIEF.md
# Re-encode Error Estimator with Node-Sync Monitor

This block sits behind a convolutional decoder and estimates how many channel bits arrived wrong. Each decoded bit is passed through a local copy of the encoder, built from the same generator polynomials, to rebuild the coded bits the transmitter must have sent. Those rebuilt bits are compared with the hard decisions taken from the received soft symbols. The received symbols pass through a delay line that matches the decoder latency, so each comparison uses the symbols that belong to the bit under test. Erased symbols are left out of the comparison.

Two independent windowed counters consume the per-bit mismatch count. The error-rate window runs over a programmable number of decoded bits. At the end of each window it latches the total into a held output and starts again from zero. Its running count is visible while it grows, so single error positions can be seen. The node-sync window has its own length and an error threshold. At the end of each of its windows it decides whether the decoder is locked or not, and it holds that decision until the next window ends. Both counters saturate rather than wrap.

Top module: `reencode_ber_monitor`

## Requirements
- R1: For each valid decoded bit b with the previous K-1 decoded bits, coded bit j is the XOR of the taps selected by polynomial j over {b, previous bits}. Polynomial bit K-1 taps b and bit 0 taps the oldest bit. With the defaults (K=3, N=2), symbol 0 uses 3'b111 and symbol 1 uses 3'b101. Symbol 0 occupies the most significant W bits of `rx_sym`. The hard decision of a symbol is its MSB (1 means encoded 1), and each non-erased symbol whose hard decision differs from its coded bit is one error.
- R2: A symbol whose bits are all zero is an erasure and never counts as an error, whatever the coded bit is.
- R3: The symbol vector presented in cycle c is compared with the decoded bit presented in cycle c+DELAY (default DELAY=4). The re-encoder history advances only in cycles with `dec_valid` high, and symbols whose partner cycle has `dec_valid` low are never counted. After reset the delay line holds erasures.
- R4: `err_count` rises by the number of errors of a valid decoded bit on the clock edge that samples that bit.
- R5: The error-rate window ends on the valid decoded bit that brings the window's bit count to `ber_period`; a period of 0 or 1 ends the window on every bit. On that edge `ber_latched` takes the window total including that bit, and `err_count` returns to 0.
- R6: The node-sync window ends on the valid decoded bit that brings its bit count to `ns_period`, with its own position independent of the error-rate window. On that edge `in_sync`=1 and `out_sync`=0 if the window total is below `ns_threshold`, otherwise `in_sync`=0 and `out_sync`=1. `ns_count` returns to 0.
- R7: `in_sync`, `out_sync` and `ber_latched` keep their values between window ends.
- R8: `err_count` saturates at 65535 and `ns_count` at 255 instead of wrapping.
- R9: Synchronous active-high reset clears both counts, `ber_latched`, `in_sync`, `out_sync`, the re-encoder history and the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_sym | input | N*W (6) | Received soft symbol vector, symbol 0 in the MSBs |
| dec_valid | input | 1 | Decoded bit strobe |
| dec_bit | input | 1 | Decoded bit |
| ber_period | input | 24 | Error-rate window length in decoded bits |
| ns_period | input | 8 | Node-sync window length in decoded bits |
| ns_threshold | input | 8 | Error count at or above which sync is lost |
| err_count | output | 16 | Running error count of the current error-rate window |
| ber_latched | output | 16 | Total of the last completed error-rate window |
| ns_count | output | 8 | Running error count of the current node-sync window |
| in_sync | output | 1 | Last node-sync window was below threshold |
| out_sync | output | 1 | Last node-sync window reached threshold |

## Verification
The bench goes after the alignment between symbol and decoded-bit streams, including gaps in `dec_valid` where garbage symbols sit in the delay line. A design off by one stage or one that advances its encoder on idle cycles would count those garbage symbols. It exercises erasures combined with flipped symbols, a window total exactly equal to the threshold (a `<=` comparison would report lock) and a zero-length error-rate window. It also drives both counters far past their maximum, where a wrapping counter would show a small value instead of all ones.

// File: rtl/ber_mon_pkg.sv
package ber_mon_pkg;

    // Node synchronisation decision held between windows.
    typedef enum logic [1:0] {
        SYNC_NONE   = 2'd0,
        SYNC_LOCKED = 2'd1,
        SYNC_LOST   = 2'd2
    } sync_state_e;

    // Classified received symbol.
    typedef struct packed {
        logic hard;     // 1 = encoded one
        logic erased;   // all bits zero
    } sym_class_t;

    function automatic sym_class_t classify(input logic msb, input logic any_set);
        sym_class_t c;
        c.hard   = msb;
        c.erased = ~any_set;
        return c;
    endfunction

    // Width of a per-bit error count for n symbols.
    function automatic int err_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sym_delay.sv
module sym_delay #(
    parameter int W     = 6,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/conv_reencode.sv
module conv_reencode
    import ber_mon_pkg::*;
#(
    parameter int               K     = 3,
    parameter int               N     = 2,
    parameter int               W     = 3,
    parameter logic [N*K-1:0]   POLYS = 6'b111_101,
    localparam int              EW    = err_width(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dec_valid,
    input  logic           dec_bit,
    input  logic [N*W-1:0] rx_vec,
    output logic [EW-1:0]  err_inc
);
    logic [K-2:0] hist;
    logic [K-1:0] win;
    logic [N-1:0] miss;

    assign win = {dec_bit, hist};

    always_ff @(posedge clk) begin
        if (rst)            hist <= '0;
        else if (dec_valid) hist <= win[K-1:1];
    end

    for (genvar j = 0; j < N; j++) begin : g_sym
        localparam logic [K-1:0] TAPS = POLYS[(N-j)*K-1 -: K];
        logic [W-1:0] sym;
        sym_class_t   cls;
        logic         coded;
        assign sym     = rx_vec[(N-j)*W-1 -: W];
        assign cls     = classify(sym[W-1], |sym);
        assign coded   = ^(win & TAPS);
        assign miss[j] = ~cls.erased & (cls.hard ^ coded);
    end

    always_comb begin
        err_inc = '0;
        for (int j = 0; j < N; j++)
            err_inc = err_inc + EW'(dec_valid & miss[j]);
    end

    // R3: history frozen on idle cycles
    a_r3_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> $stable(hist));
    // R2: an all-erased vector never yields an error
    a_r2_erasure: assert property (@(posedge clk) disable iff (rst)
        (rx_vec == '0) |-> (err_inc == '0));
    // R3: no errors without a decoded bit
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (err_inc == '0));
endmodule

// File: rtl/window_acc.sv
module window_acc #(
    parameter int CW = 16,
    parameter int PW = 24,
    parameter int EW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [EW-1:0] add,
    input  logic [PW-1:0] period,
    output logic [CW-1:0] run,
    output logic          fire,
    output logic [CW-1:0] sum
);
    logic [CW:0]   wide;
    logic [PW-1:0] pos;
    logic          last;

    assign wide = {1'b0, run} + {{(CW + 1 - EW){1'b0}}, add};
    assign sum  = wide[CW] ? {CW{1'b1}} : wide[CW-1:0];
    assign last = ({1'b0, pos} + {{PW{1'b0}}, 1'b1}) >= {1'b0, period};
    assign fire = step & last;

    always_ff @(posedge clk) begin
        if (rst || fire) begin
            run <= '0;
            pos <= '0;
        end else if (step) begin
            run <= sum;
            pos <= pos + 1'b1;
        end
    end

    // R8: the running count never falls except at a window end
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !$past(fire) |-> (run >= $past(run)));
    // R5 / R6: a window end leaves the count cleared
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        $past(fire) |-> (run == '0));
endmodule

// File: rtl/reencode_ber_monitor.sv
module reencode_ber_monitor
    import ber_mon_pkg::*;
#(
    parameter int             K      = 3,
    parameter int             N      = 2,
    parameter int             W      = 3,
    parameter logic [N*K-1:0] POLYS  = 6'b111_101,
    parameter int             DELAY  = 4,
    parameter int             BER_CW = 16,
    parameter int             BER_PW = 24,
    parameter int             NS_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N*W-1:0]    rx_sym,
    input  logic              dec_valid,
    input  logic              dec_bit,
    input  logic [BER_PW-1:0] ber_period,
    input  logic [NS_W-1:0]   ns_period,
    input  logic [NS_W-1:0]   ns_threshold,
    output logic [BER_CW-1:0] err_count,
    output logic [BER_CW-1:0] ber_latched,
    output logic [NS_W-1:0]   ns_count,
    output logic              in_sync,
    output logic              out_sync
);
    localparam int EW = err_width(N);

    logic [N*W-1:0]    rx_aligned;
    logic [EW-1:0]     err_inc;
    logic              ber_fire, ns_fire;
    logic [BER_CW-1:0] ber_sum;
    logic [NS_W-1:0]   ns_sum;
    sync_state_e       sync_q;

    sym_delay #(.W(N*W), .DEPTH(DELAY)) u_delay (
        .clk(clk), .rst(rst), .din(rx_sym), .dout(rx_aligned)
    );

    conv_reencode #(.K(K), .N(N), .W(W), .POLYS(POLYS)) u_enc (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_bit(dec_bit),
        .rx_vec(rx_aligned), .err_inc(err_inc)
    );

    window_acc #(.CW(BER_CW), .PW(BER_PW), .EW(EW)) u_ber_win (
        .clk(clk), .rst(rst), .step(dec_valid), .add(err_inc),
        .period(ber_period), .run(err_count), .fire(ber_fire), .sum(ber_sum)
    );

    window_acc #(.CW(NS_W), .PW(NS_W), .EW(EW)) u_ns_win (
        .clk(clk), .rst(rst), .step(dec_valid), .add(err_inc),
        .period(ns_period), .run(ns_count), .fire(ns_fire), .sum(ns_sum)
    );

    always_ff @(posedge clk) begin
        if (rst)           ber_latched <= '0;
        else if (ber_fire) ber_latched <= ber_sum;
    end

    always_ff @(posedge clk) begin
        if (rst)          sync_q <= SYNC_NONE;
        else if (ns_fire) sync_q <= (ns_sum < ns_threshold) ? SYNC_LOCKED : SYNC_LOST;
    end

    assign in_sync  = (sync_q == SYNC_LOCKED);
    assign out_sync = (sync_q == SYNC_LOST);

    // R7: latched total held between error-rate window ends
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(ber_fire) |-> $stable(ber_latched));
    // R7: sync flags held between node-sync window ends
    a_r7_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(ns_fire) |-> ($stable(in_sync) && $stable(out_sync)));
    // R6: below-threshold window reports lock
    a_r6_lock: assert property (@(posedge clk) disable iff (rst)
        ($past(ns_fire) && ($past(ns_sum) < $past(ns_threshold))) |-> (in_sync && !out_sync));
    // R6: at-or-above-threshold window reports loss
    a_r6_loss: assert property (@(posedge clk) disable iff (rst)
        ($past(ns_fire) && ($past(ns_sum) >= $past(ns_threshold))) |-> (out_sync && !in_sync));
    // R9: reset leaves all outputs cleared
    a_r9_reset: assert property (@(posedge clk)
        $past(rst) |-> (err_count == '0 && ber_latched == '0 && ns_count == '0
                        && !in_sync && !out_sync));
endmodule

// File: tb/sim_reencode_ber_monitor.sv
`timescale 1ns/1ps
module sim_reencode_ber_monitor;
    localparam int DELAY = 4;
    localparam int NT    = 24;
    // entry: {valid, bit, corrupt[1:0], erase[1:0]}; index 1 = symbol 0 (MSBs)
    localparam logic [5:0] TBL [NT] = '{
        6'b11_00_00, 6'b10_00_00, 6'b11_01_00, 6'b11_10_00,
        6'b10_11_00, 6'b00_11_00, 6'b11_11_11, 6'b10_11_01,
        6'b11_00_10, 6'b10_01_00, 6'b00_00_00, 6'b11_11_00,
        6'b11_00_00, 6'b10_00_00, 6'b11_10_01, 6'b10_01_10,
        6'b11_11_00, 6'b11_11_00, 6'b10_00_00, 6'b00_11_11,
        6'b11_01_00, 6'b10_00_00, 6'b11_00_00, 6'b10_10_00
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  rx_sym = '0;
    logic        dec_valid = 1'b0;
    logic        dec_bit = 1'b0;
    logic [23:0] ber_period = 24'd5;
    logic [7:0]  ns_period = 8'd4;
    logic [7:0]  ns_threshold = 8'd2;
    logic [15:0] err_count, ber_latched;
    logic [7:0]  ns_count;
    logic        in_sync, out_sync;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    int m_run, m_lat, m_bpos, m_nrun, m_npos, m_in, m_out;
    logic [5:0] sv [NT];

    always #5 clk = ~clk;

    reencode_ber_monitor u0 (
        .clk(clk), .rst(rst), .rx_sym(rx_sym), .dec_valid(dec_valid),
        .dec_bit(dec_bit), .ber_period(ber_period), .ns_period(ns_period),
        .ns_threshold(ns_threshold), .err_count(err_count),
        .ber_latched(ber_latched), .ns_count(ns_count),
        .in_sync(in_sync), .out_sync(out_sync)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; dec_valid = 1'b0; rx_sym = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_run = 0; m_lat = 0; m_bpos = 0; m_nrun = 0; m_npos = 0; m_in = 0; m_out = 0;
    endtask

    task automatic check_all(input string ctx);
        chk({ctx, " R1/R2/R3/R4 err_count"}, err_count, m_run);
        chk({ctx, " R5 ber_latched"}, ber_latched, m_lat);
        chk({ctx, " R6 ns_count"}, ns_count, m_nrun);
        chk({ctx, " R6/R7 in_sync"}, in_sync, m_in);
        chk({ctx, " R6/R7 out_sync"}, out_sync, m_out);
    endtask

    // Model of one valid decoded bit carrying e errors, from the requirements.
    task automatic model_step(input int e);
        int bp, np;
        bp = (ber_period < 1) ? 1 : int'(ber_period);
        np = (ns_period < 1) ? 1 : int'(ns_period);
        m_run = (m_run + e > 65535) ? 65535 : m_run + e;
        m_nrun = (m_nrun + e > 255) ? 255 : m_nrun + e;
        m_bpos++; m_npos++;
        if (m_bpos >= bp) begin m_lat = m_run; m_run = 0; m_bpos = 0; end
        if (m_npos >= np) begin
            m_in  = (m_nrun < int'(ns_threshold)) ? 1 : 0;
            m_out = 1 - m_in;
            m_nrun = 0; m_npos = 0;
        end
    endtask

    function automatic logic [1:0] enc(input logic b, input logic [1:0] st);
        logic [2:0] w;
        w = {b, st};
        return {^(w & 3'b111), ^(w & 3'b101)};
    endfunction

    task automatic build_syms();
        logic [1:0] st, c;
        logic h;
        st = 2'b00;
        for (int i = 0; i < NT; i++) begin
            if (!TBL[i][5]) sv[i] = 6'b101_101;
            else begin
                c = enc(TBL[i][4], st);
                st = {TBL[i][4], st[1]};
                for (int s = 0; s < 2; s++) begin
                    h = c[s] ^ TBL[i][2+s];
                    sv[i][s*3 +: 3] = TBL[i][s] ? 3'b000 : (h ? 3'b101 : 3'b011);
                end
            end
        end
    endtask

    task automatic run_table(input int bp, input int np, input int thr, input string ctx);
        logic [5:0] e;
        ber_period = 24'(bp); ns_period = 8'(np); ns_threshold = 8'(thr);
        do_reset();
        for (int i = 0; i < NT + DELAY; i++) begin
            rx_sym = (i < NT) ? sv[i] : 6'b101_101;
            if (i >= DELAY) begin
                e = TBL[i-DELAY];
                dec_valid = e[5]; dec_bit = e[4];
            end else begin
                dec_valid = 1'b0; dec_bit = 1'b0;
            end
            @(posedge clk);
            if (i >= DELAY && e[5])
                model_step(int'(e[3] & ~e[1]) + int'(e[2] & ~e[0]));
            @(negedge clk);
            check_all(ctx);
        end
        dec_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        build_syms();
        // R9: state after reset
        do_reset();
        check_all("reset R9");

        // Table walk: R1..R7, window 5 / sync window 4, threshold 2
        run_table(5, 4, 2, "table_a");
        // Zero-length error-rate window (R5), threshold 1
        run_table(0, 3, 1, "table_b");

        // R8: saturation with all-zero data and both symbols flipped
        ber_period = 24'hFFFFFF; ns_period = 8'd255; ns_threshold = 8'd255;
        do_reset();
        rx_sym = 6'b101_101; dec_bit = 1'b0; dec_valid = 1'b1;
        repeat (200) @(negedge clk);
        chk("R8 ns_count saturated", ns_count, 255);
        repeat (33000) @(negedge clk);
        chk("R8 err_count saturated", err_count, 65535);
        dec_valid = 1'b0;

        // R9: reset in mid-run clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_run = 0; m_lat = 0; m_nrun = 0; m_in = 0; m_out = 0;
        check_all("midrun R9");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule